// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple register bus and the byte-level side of a small serial port. It decodes a 16-byte window that holds four 32-bit registers. The first register returns received data, the second accepts a byte to transmit, the third reports status and the fourth holds control. The register index is taken from byte-address bits [3:2], so bits [1:0] are ignored.

Received bytes come in on a byte-wide input with a one-cycle strobe. They are kept in an eight-entry circular queue until software reads them. A transmit write places one byte in a holding stage, which offers it on a valid/ready output. A sticky pending flag drives a single interrupt line, gated by an enable bit in control. Serialization, baud timing and line-error detection happen elsewhere. The three error bits in status read as zero here.

Bus reads are combinational: `bus_rdata` reflects the addressed register during the access cycle. Side effects such as popping the queue or clearing the pending flag take place at the closing clock edge.

Top module: `serial_regfront`

## Requirements
- R1: The register index is `bus_addr[3:2]`: 0 receive data, 1 transmit data, 2 status, 3 control. Address bits [1:0] do not select anything. A read of index 1 returns 0. A read of index 3 returns the last value written there.
- R2: After reset, status reads 0x04 (only bit2 set), `irq` is 0 and `tx_valid` is 0.
- R3: Status bit0 is 1 when the queue holds at least one byte. Status bit1 is 1 when it holds exactly 8 bytes.
- R4: A byte whose strobe arrives while the queue holds 8 entries is dropped. The count and stored bytes stay unchanged.
- R5: A read of index 0 returns the oldest stored byte in bits [7:0] and removes it. Bytes come out in arrival order, across pointer wrap.
- R6: A read of index 0 on an empty queue leaves the count at 0 (no underflow).
- R7: A control write with bit1 set empties the queue at that edge. The written word is also kept as the control value.
- R8: Status bit4 (pending) is set at any edge after which the queue is nonempty, and by any transmit write. A status read clears it only if the queue is empty after that edge.
- R9: `irq` equals pending AND control bit4.
- R10: A transmit write, when no byte is held, puts `bus_wdata[7:0]` on `tx_byte` with `tx_valid` high until an edge with `tx_ready` high. Status bit2 is 0 while a byte is held.
- R11: A transmit write while a byte is held is dropped and sets status bit3. Status bit3 stays set until a control write with bit0 set, which also discards the held byte.
- R12: Writes to index 2 change no register and no output.
- R13: A receive strobe and a data read in the same cycle both take effect: the count stays unchanged and order is preserved. If the queue was full before that cycle, the incoming byte is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_byte | input | 8 | Incoming byte |
| rx_strobe | input | 1 | Incoming byte valid for one cycle |
| tx_byte | output | 8 | Byte offered for transmission |
| tx_valid | output | 1 | A byte is being offered |
| tx_ready | input | 1 | Consumer accepts the offered byte |
| irq | output | 1 | Interrupt request |

## Verification
The receive strobe and a bus read of receive data can land in the same cycle, so the queue must push and pop at once. The bench provokes this on a half-full queue and on a full one. It then judges by the returned byte, the status count flags and the order of the bytes that follow. In the full case, the incoming byte must vanish even though a slot frees at that same edge.

// File: rtl/serial_regfront_pkg.sv
package serial_regfront_pkg;
  typedef enum logic [1:0] {
    IDX_RXD  = 2'd0,
    IDX_TXD  = 2'd1,
    IDX_STAT = 2'd2,
    IDX_CTRL = 2'd3
  } reg_idx_e;

  localparam int CTRL_TX_FLUSH = 0;
  localparam int CTRL_RX_FLUSH = 1;
  localparam int CTRL_IRQ_EN   = 4;

  localparam int ST_RX_AVAIL = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_IDLE  = 2;
  localparam int ST_TX_OVF   = 3;
  localparam int ST_PEND     = 4;
endpackage

// File: rtl/sr_rx_queue.sv
module sr_rx_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  input  logic             clr,
  output logic [DW-1:0]    head_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);
  logic [DW-1:0]    slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;
  logic [PTR_W-1:0] rd_slot;

  always_comb begin
    do_push = push && (cnt_q < CNT_W'(DEPTH)) && !clr;
    do_pop  = pop && (cnt_q != '0) && !clr;
    rd_slot = wptr_q - PTR_W'(cnt_q);
    wptr_d  = wptr_q;
    cnt_d   = cnt_q;
    if (clr) begin
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (do_push) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wptr_q] <= push_data;
  end

  assign head_data = slot_q[rd_slot];
  assign count     = cnt_q;
  assign count_nxt = cnt_d;

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(DEPTH) && push && !pop && !clr) |=> (cnt_q == CNT_W'(DEPTH)) && $stable(wptr_q));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop && !push) |=> (cnt_q == '0));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sr_tx_hold.sv
module sr_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          flush,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_byte,
  output logic          tx_valid,
  output logic          ovf
);
  logic          held_q, held_d;
  logic [DW-1:0] data_q;
  logic          data_en;
  logic          ovf_q, ovf_d;

  always_comb begin
    held_d  = held_q;
    ovf_d   = ovf_q;
    data_en = 1'b0;
    if (flush) begin
      held_d = 1'b0;
      ovf_d  = 1'b0;
    end else begin
      if (held_q && tx_ready) held_d = 1'b0;
      if (load) begin
        if (held_q) ovf_d = 1'b1;
        else begin
          held_d  = 1'b1;
          data_en = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      ovf_q  <= 1'b0;
      data_q <= '0;
    end else begin
      held_q <= held_d;
      ovf_q  <= ovf_d;
      if (data_en) data_q <= load_data;
    end
  end

  assign tx_byte  = data_q;
  assign tx_valid = held_q;
  assign ovf      = ovf_q;

  a_r10_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush) |=> tx_valid && $stable(tx_byte));
  a_r11_busy_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && load && !flush) |=> ovf && $stable(tx_byte));
endmodule

// File: rtl/serial_regfront.sv
module serial_regfront
  import serial_regfront_pkg::*;
#(
  parameter int RXQ_DEPTH = 8,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 4,
  localparam int CNT_W    = $clog2(RXQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              irq
);
  reg_idx_e          idx;
  logic              acc_rd, acc_wr;
  logic              q_pop, q_clr, tx_load, tx_flush, ctrl_en;
  logic [BYTE_W-1:0] head_data;
  logic [CNT_W-1:0]  q_count, q_count_nxt;
  logic              tx_ovf;
  logic [WORD_W-1:0] ctrl_q;
  logic              pend_q, pend_d;
  logic [WORD_W-1:0] status;

  always_comb begin
    idx      = reg_idx_e'(bus_addr[3:2]);
    acc_rd   = bus_sel && !bus_wr;
    acc_wr   = bus_sel && bus_wr;
    q_pop    = acc_rd && (idx == IDX_RXD);
    ctrl_en  = acc_wr && (idx == IDX_CTRL);
    q_clr    = ctrl_en && bus_wdata[CTRL_RX_FLUSH];
    tx_flush = ctrl_en && bus_wdata[CTRL_TX_FLUSH];
    tx_load  = acc_wr && (idx == IDX_TXD);
  end

  sr_rx_queue #(.DEPTH(RXQ_DEPTH), .DW(BYTE_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_strobe),
    .push_data (rx_byte),
    .pop       (q_pop),
    .clr       (q_clr),
    .head_data (head_data),
    .count     (q_count),
    .count_nxt (q_count_nxt)
  );

  sr_tx_hold #(.DW(BYTE_W)) u_txh (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_data (bus_wdata[BYTE_W-1:0]),
    .flush     (tx_flush),
    .tx_ready  (tx_ready),
    .tx_byte   (tx_byte),
    .tx_valid  (tx_valid),
    .ovf       (tx_ovf)
  );

  always_comb begin
    pend_d = pend_q;
    if (acc_rd && (idx == IDX_STAT)) pend_d = 1'b0;
    if (tx_load) pend_d = 1'b1;
    if (q_count_nxt != '0) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (ctrl_en) ctrl_q <= bus_wdata;
    end
  end

  always_comb begin
    status              = '0;
    status[ST_RX_AVAIL] = (q_count != '0);
    status[ST_RX_FULL]  = (q_count == CNT_W'(RXQ_DEPTH));
    status[ST_TX_IDLE]  = !tx_valid;
    status[ST_TX_OVF]   = tx_ovf;
    status[ST_PEND]     = pend_q;
  end

  always_comb begin
    case (idx)
      IDX_RXD:  bus_rdata = WORD_W'(head_data);
      IDX_STAT: bus_rdata = status;
      IDX_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = pend_q && ctrl_q[CTRL_IRQ_EN];

  a_r8_pend_while_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count != '0) |-> pend_q);
  a_r8_txwrite_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> pend_q);
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CTRL_IRQ_EN]);
endmodule

// File: tb/serial_regfront_tb_top.sv
`timescale 1ns/1ps
module serial_regfront_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  rx_byte, tx_byte;
  logic        rx_strobe, tx_valid, tx_ready, irq;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  serial_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_byte(rx_byte), .rx_strobe(rx_strobe), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic rv, input logic [7:0] rb, output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    rx_strobe = rv; rx_byte = rb;
    #1 q = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; rx_strobe = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q;
    cyc(1'b1, a, d, 1'b0, 8'h00, q);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    cyc(1'b0, a, 32'h0, 1'b0, 8'h00, q);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_strobe = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_strobe = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] q;
    @(negedge clk);
    chk("R2 irq", 32'(irq), 0);
    chk("R2 tx_valid", 32'(tx_valid), 0);
    rd(4'h8, q); chk("R2 status", q, 32'h04);
  endtask

  task automatic t_fill_drain;
    logic [31:0] q;
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    rd(4'h8, q); chk("R3 full status", q, 32'h17);
    push(8'hEE);
    rd(4'h8, q); chk("R4 still full", q, 32'h17);
    for (int i = 0; i < 8; i++) begin
      rd(4'h0, q); chk("R5 order", q, 32'h40 + i);
    end
    rd(4'h8, q); chk("R4 dropped byte absent", q, 32'h14);
    rd(4'h0, q);
    rd(4'h8, q); chk("R6 no underflow", q, 32'h04);
  endtask

  task automatic t_push_pop_same;
    logic [31:0] q;
    push(8'h11); push(8'h22);
    cyc(1'b0, 4'h0, 32'h0, 1'b1, 8'h33, q); chk("R13 read byte", q, 32'h11);
    rd(4'h8, q); chk("R13 count kept", q, 32'h15);
    rd(4'h0, q); chk("R13 order a", q, 32'h22);
    rd(4'h0, q); chk("R13 order b", q, 32'h33);
    rd(4'h8, q); chk("R8 read clears when empty", q, 32'h14);
    rd(4'h8, q); chk("R8 pending cleared", q, 32'h04);
    for (int i = 0; i < 8; i++) push(8'h60 + 8'(i));
    cyc(1'b0, 4'h0, 32'h0, 1'b1, 8'h99, q); chk("R13 full read byte", q, 32'h60);
    rd(4'h8, q); chk("R13 full drop count", q, 32'h15);
    for (int i = 1; i < 8; i++) begin
      rd(4'h0, q); chk("R5 wrap order", q, 32'h60 + i);
    end
    rd(4'h8, q); chk("R13 no extra byte", q, 32'h14);
  endtask

  task automatic t_rx_flush;
    logic [31:0] q;
    push(8'h01); push(8'h02); push(8'h03);
    wr(4'hC, 32'h0000_0002);
    rd(4'h8, q); chk("R7 queue emptied", q, 32'h14);
    rd(4'hC, q); chk("R7 control stored", q, 32'h02);
    push(8'h7B);
    rd(4'h0, q); chk("R7 pointers restart", q, 32'h7B);
    rd(4'h8, q);
  endtask

  task automatic t_irq;
    logic [31:0] q;
    wr(4'hC, 32'h10);
    @(negedge clk); chk("R9 idle irq", 32'(irq), 0);
    push(8'h5A);
    @(negedge clk); chk("R9 irq raised", 32'(irq), 1);
    wr(4'hC, 32'h00);
    @(negedge clk); chk("R9 masked", 32'(irq), 0);
    wr(4'hC, 32'h12);
    @(negedge clk); chk("R8 sticky after flush", 32'(irq), 1);
    rd(4'h8, q); chk("R8 status", q, 32'h14);
    @(negedge clk); chk("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_tx;
    logic [31:0] q;
    wr(4'h4, 32'h1A5);
    @(negedge clk);
    chk("R10 valid", 32'(tx_valid), 1);
    chk("R10 byte", 32'(tx_byte), 32'hA5);
    rd(4'h8, q); chk("R10 busy status", q, 32'h10);
    wr(4'h4, 32'h33);
    rd(4'h8, q); chk("R11 overflow status", q, 32'h18);
    @(negedge clk); chk("R11 byte kept", 32'(tx_byte), 32'hA5);
    tx_ready = 1'b1;
    @(posedge clk); #1 tx_ready = 1'b0;
    @(negedge clk); chk("R10 released", 32'(tx_valid), 0);
    rd(4'h8, q); chk("R11 flag sticky", q, 32'h0C);
    wr(4'hC, 32'h01);
    rd(4'h8, q); chk("R11 flag cleared", q, 32'h04);
    rd(4'h4, q); chk("R1 tx read zero", q, 32'h0);
    rd(4'hF, q); chk("R1 alias control", q, 32'h01);
  endtask

  task automatic t_stat_write;
    logic [31:0] q;
    wr(4'h8, 32'hFF);
    rd(4'h8, q); chk("R12 status", q, 32'h04);
    rd(4'hC, q); chk("R12 control", q, 32'h01);
    @(negedge clk);
    chk("R12 irq", 32'(irq), 0);
    chk("R12 tx_valid", 32'(tx_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_byte = '0; rx_strobe = 1'b0; tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill_drain();
    t_push_pop_same();
    t_rx_flush();
    t_irq();
    t_tx();
    t_stat_write();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule